// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control half of a successive-approximation analog-to-digital converter. A start pulse begins a conversion. The block clears its approximation register and then walks a single trial bit from the most significant position downward, one position per clock. It presents each trial code to an external DAC. On the next edge it reads one comparator bit, which is high when the DAC value lies above the analog input, and uses it to decide whether that bit stays set.

A length select, sampled together with the start pulse, chooses between a full-width cycle and a shortened cycle. The shortened cycle resolves only the upper bits and leaves the remaining low result bits at zero. While a conversion runs, the busy flag is high and further start requests have no effect. When the last trial is committed, busy drops, a one-cycle done pulse is issued, and the finished code appears on the result output. The result then stays there until a later conversion completes.

Top module: `sar_seq_core`

## Requirements
- R1: After reset, busy_o, done_o, result_o and trial_o are all zero.
- R2: A start accepted while idle clears the approximation register, so the first trial code is exactly the MSB alone (0x800 at 12 bits), whatever the previous result was.
- R3: One bit is tried per clock, MSB first. Each trial code is the bits already committed plus the current bit forced to 1. trial_o is zero while idle.
- R4: On the edge after a trial, cmp_i = 1 (DAC above input) clears the trial bit and cmp_i = 0 keeps it. With an ideal comparator, a full cycle therefore returns the input code exactly.
- R5: short_i = 0 at start gives a 12-trial cycle, with busy_o high for 12 cycles. short_i = 1 gives an 8-trial cycle with busy_o high for 8 cycles, and result bits [3:0] are forced to zero.
- R6: The length choice is captured with the start and held for the whole cycle. Later changes of short_i have no effect on that cycle.
- R7: start_i pulses while busy_o is high are ignored. The running cycle keeps its length and result, and no second cycle follows.
- R8: busy_o rises on the edge that accepts start. done_o is high for exactly one cycle, namely the first cycle in which busy_o is low again.
- R9: result_o changes only in the cycle in which done_o is high. It holds its value at all other times, even when the comparator input moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled on the rising edge |
| short_i | input | 1 | Length select at start: 0 = full width, 1 = short cycle |
| cmp_i | input | 1 | Comparator: 1 when the DAC value exceeds the input |
| trial_o | output | WIDTH | Trial code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | WIDTH | Last finished conversion code |

## Verification
Counting from the edge that accepts start, busy_o and the MSB-only trial code are visible right after that edge. The second trial code is visible one edge later. busy_o falls, done_o pulses and result_o updates right after edge 12 for a full cycle, or edge 8 for a short one. The bench drives and samples only on falling clock edges. After each start it observes a fixed window of falling edges, counting busy and done samples and capturing the first two trial codes at the first and second samples. It then compares these against the values given by the requirements. The comparator is modelled in the bench as an ideal comparison of the trial code against a chosen input code, so the expected result of every pattern follows directly from R4 and R5.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int SAR_WIDTH_DEF = 12;
    localparam int SAR_SHORT_DEF = 8;

    typedef enum logic [0:0] {
        SAR_IDLE = 1'b0,
        SAR_RUN  = 1'b1
    } sar_state_e;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int WIDTH      = SAR_WIDTH_DEF,
    parameter int SHORT_BITS = SAR_SHORT_DEF,
    parameter int PTR_W      = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             short_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             clear_o,
    output logic             commit_o,
    output logic             last_o,
    output logic             short_o,
    output logic [PTR_W-1:0] ptr_o
);

    localparam logic [PTR_W-1:0] PTR_TOP   = PTR_W'(WIDTH - 1);
    localparam logic [PTR_W-1:0] PTR_SHORT = PTR_W'(WIDTH - SHORT_BITS);
    localparam logic [PTR_W-1:0] PTR_FULL  = '0;

    typedef struct packed {
        sar_state_e       state;
        logic [PTR_W-1:0] ptr;
        logic             short_len;
        logic             done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  at_stop;

    // Stop position depends on the length captured at start, not the live input
    assign at_stop = (ctrl_q.ptr == (ctrl_q.short_len ? PTR_SHORT : PTR_FULL));

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        unique case (ctrl_q.state)
            SAR_IDLE: begin
                if (start_i) begin
                    ctrl_d.state     = SAR_RUN;
                    ctrl_d.ptr       = PTR_TOP;
                    ctrl_d.short_len = short_i;
                end
            end
            SAR_RUN: begin
                if (at_stop) begin
                    ctrl_d.state = SAR_IDLE;
                    ctrl_d.done  = 1'b1;
                end else begin
                    ctrl_d.ptr = ctrl_q.ptr - 1'b1;
                end
            end
            default: ctrl_d.state = SAR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: SAR_IDLE, ptr: '0, short_len: 1'b0, done: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy_o   = (ctrl_q.state == SAR_RUN);
    assign done_o   = ctrl_q.done;
    assign clear_o  = (ctrl_q.state == SAR_IDLE) && start_i;
    assign commit_o = busy_o;
    assign last_o   = busy_o && at_stop;
    assign short_o  = ctrl_q.short_len;
    assign ptr_o    = ctrl_q.ptr;

endmodule

// File: rtl/sar_seq_mask.sv
module sar_seq_mask
    import sar_seq_pkg::*;
#(
    parameter int WIDTH      = SAR_WIDTH_DEF,
    parameter int SHORT_BITS = SAR_SHORT_DEF,
    parameter int PTR_W      = $clog2(WIDTH)
) (
    input  logic [PTR_W-1:0] ptr_i,
    input  logic             short_i,
    output logic [WIDTH-1:0] bit_sel_o,
    output logic [WIDTH-1:0] keep_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bit_sel_o[i] = (ptr_i == PTR_W'(i));
        if (i >= WIDTH - SHORT_BITS) begin : g_upper
            assign keep_o[i] = 1'b1;
        end else begin : g_lower
            assign keep_o[i] = !short_i;
        end
    end

endmodule

// File: rtl/sar_seq_reg.sv
module sar_seq_reg
    import sar_seq_pkg::*;
#(
    parameter int WIDTH = SAR_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             commit_i,
    input  logic             last_i,
    input  logic             cmp_i,
    input  logic [WIDTH-1:0] bit_sel_i,
    input  logic [WIDTH-1:0] keep_i,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] result_o
);

    typedef struct packed {
        logic [WIDTH-1:0] approx;
        logic [WIDTH-1:0] result;
    } reg_t;

    reg_t             reg_d, reg_q;
    logic [WIDTH-1:0] approx_next;

    always_comb begin
        approx_next = reg_q.approx;
        if (clear_i) begin
            approx_next = '0;
        end else if (commit_i && !cmp_i) begin
            approx_next = reg_q.approx | bit_sel_i;
        end
        reg_d.approx = approx_next;
        reg_d.result = last_i ? (approx_next & keep_i) : reg_q.result;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign trial_o  = commit_i ? (reg_q.approx | bit_sel_i) : '0;
    assign result_o = reg_q.result;

endmodule

// File: rtl/sar_seq_core.sv
module sar_seq_core
    import sar_seq_pkg::*;
#(
    parameter int WIDTH      = SAR_WIDTH_DEF,
    parameter int SHORT_BITS = SAR_SHORT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             short_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);

    localparam int PTR_W = $clog2(WIDTH);

    logic             clear, commit, last, short_cap;
    logic [PTR_W-1:0] ptr;
    logic [WIDTH-1:0] bit_sel, keep;

    sar_seq_ctrl #(
        .WIDTH     (WIDTH),
        .SHORT_BITS(SHORT_BITS),
        .PTR_W     (PTR_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .short_i (short_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .clear_o (clear),
        .commit_o(commit),
        .last_o  (last),
        .short_o (short_cap),
        .ptr_o   (ptr)
    );

    sar_seq_mask #(
        .WIDTH     (WIDTH),
        .SHORT_BITS(SHORT_BITS),
        .PTR_W     (PTR_W)
    ) u_mask (
        .ptr_i    (ptr),
        .short_i  (short_cap),
        .bit_sel_o(bit_sel),
        .keep_o   (keep)
    );

    sar_seq_reg #(
        .WIDTH(WIDTH)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .commit_i (commit),
        .last_i   (last),
        .cmp_i    (cmp_i),
        .bit_sel_i(bit_sel),
        .keep_i   (keep),
        .trial_o  (trial_o),
        .result_o (result_o)
    );

endmodule

// File: rtl/sar_seq_core_chk.sv
module sar_seq_core_chk #(
    parameter int WIDTH      = 12,
    parameter int SHORT_BITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             short_i,
    input logic [WIDTH-1:0] trial_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] result_o
);

    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    int   busy_cnt;
    logic short_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt   <= 0;
            short_seen <= 1'b0;
        end else if (!busy_o && start_i) begin
            busy_cnt   <= 0;
            short_seen <= short_i;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 1;
        end
    end

    // R2: an accepted start yields an MSB-only first trial
    p_first_trial_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && trial_o == MSB_ONLY));

    // R3: no trial code while idle
    p_idle_trial_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (trial_o == '0));

    // R5 / R6 / R7: cycle length follows the length captured at start
    p_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_cnt == (short_seen ? SHORT_BITS : WIDTH)));

    // R5: short cycle leaves the low bits zero
    p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && short_seen) |-> (result_o[WIDTH-SHORT_BITS-1:0] == '0));

    // R8: done lasts one cycle and marks the busy fall
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $fell(busy_o));

    p_fall_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R9: result moves only with done
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

endmodule

bind sar_seq_core sar_seq_core_chk #(
    .WIDTH     (WIDTH),
    .SHORT_BITS(SHORT_BITS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .short_i (short_i),
    .trial_o (trial_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .result_o(result_o)
);

// File: tb/test_sar_seq_core.sv
`timescale 1ns/1ps
module test_sar_seq_core;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         short_sel = 1'b0;
    logic         cmp;
    logic [W-1:0] vin = '0;
    logic [W-1:0] trial, result;
    logic         busy, done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // ideal comparator: high when the DAC code is above the input code
    assign cmp = (trial > vin);

    sar_seq_core #(.WIDTH(W), .SHORT_BITS(8)) i_sar_seq_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .short_i (short_sel),
        .cmp_i   (cmp),
        .trial_o (trial),
        .busy_o  (busy),
        .done_o  (done),
        .result_o(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one conversion; inj >= 0 pulses start at that sample, flip toggles short after start
    task automatic run_conv(input int v, input bit sh, input int inj, input bit flip,
                            output int res, output int bcnt, output int dcnt,
                            output int tr0, output int tr1);
        @(negedge clk);
        vin       = W'(v);
        short_sel = sh;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (flip) short_sel = !sh;
        tr0  = int'(trial);
        tr1  = 0;
        bcnt = 0;
        dcnt = 0;
        res  = -1;
        for (int k = 0; k < 25; k++) begin
            if (busy) bcnt++;
            if (done) begin
                dcnt++;
                res = int'(result);
            end
            if (k == 1) tr1 = int'(trial);
            start = (k == inj);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic conv_check(input int v, input bit sh, input int inj, input bit flip,
                              input string tag);
        int res, bcnt, dcnt, tr0, tr1, exp_res, exp_len;
        run_conv(v, sh, inj, flip, res, bcnt, dcnt, tr0, tr1);
        exp_res = sh ? (v & 'hFF0) : v;
        exp_len = sh ? 8 : 12;
        chk(res == exp_res, {tag, " R4 R5 result"}, res, exp_res);
        chk(bcnt == exp_len, {tag, " R5 busy length"}, bcnt, exp_len);
        chk(dcnt == 1, {tag, " R8 done pulses"}, dcnt, 1);
        chk(tr0 == 'h800, {tag, " R2 first trial"}, tr0, 'h800);
        chk(tr1 == ((v & 'h800) | 'h400), {tag, " R3 second trial"}, tr1, (v & 'h800) | 'h400);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(result == '0, "R1 result", int'(result), 0);
        chk(trial == '0, "R1 trial", int'(trial), 0);
    endtask

    task automatic t_full();
        conv_check('hA5C, 1'b0, -1, 1'b0, "full A5C");
        conv_check('h000, 1'b0, -1, 1'b0, "full 000");
        conv_check('hFFF, 1'b0, -1, 1'b0, "full FFF");
        conv_check('h800, 1'b0, -1, 1'b0, "full 800");
        conv_check('h7FF, 1'b0, -1, 1'b0, "full 7FF");
        conv_check('h001, 1'b0, -1, 1'b0, "full 001");
    endtask

    task automatic t_short();
        conv_check('hFFF, 1'b1, -1, 1'b0, "short FFF");
        conv_check('h5A7, 1'b1, -1, 1'b0, "short 5A7");
        conv_check('h00F, 1'b1, -1, 1'b0, "short 00F");
    endtask

    task automatic t_len_capture();
        conv_check('h3C9, 1'b1, -1, 1'b1, "R6 short then input low");
        conv_check('hC36, 1'b0, -1, 1'b1, "R6 full then input high");
    endtask

    task automatic t_ignore();
        conv_check('h9E3, 1'b0, 3, 1'b1, "R7 start mid full");
        conv_check('h2B7, 1'b1, 7, 1'b1, "R7 start at last short trial");
    endtask

    task automatic t_clear();
        // R2: previous all-ones result must not leak into the next trial
        conv_check('hFFF, 1'b0, -1, 1'b0, "R2 prior ones");
        conv_check('h123, 1'b0, -1, 1'b0, "R2 after ones");
    endtask

    task automatic t_hold();
        logic [W-1:0] held;
        held = result;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            vin = W'(k * 'h2AB);
        end
        @(negedge clk);
        chk(result == held, "R9 result held", int'(result), int'(held));
        chk(trial == '0, "R3 idle trial", int'(trial), 0);
        chk(busy == 1'b0, "R8 idle busy", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_full();
        t_short();
        t_len_capture();
        t_ignore();
        t_clear();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule